// File: doc/BRIEF.md
# Programmable Skew Clock Phase Generator

The block derives eight clock outputs, grouped as four pairs, from a fast time-unit clock. A phase counter runs modulo N, where N (16, 26 or 44 time units) is picked by a three-level range select. Every pair produces a 50% duty waveform at the nominal period. Each pair can be shifted earlier or later by a whole number of time units, chosen by two three-level selects per pair. The step size differs between pairs. On pairs 3 and 4 the two end codes are repurposed: they give a half-rate output, and either a quarter-rate or an inverted output.

A bypass mode takes effect whenever the test select is not LOW. In this mode the outputs follow a synchronised reference input, and skew is dropped. Each pair still applies its inversion or division, counting rising reference edges. The range and the pair selects are captured only where the phase counter wraps, so a change takes effect at the start of the next period. A strobe marks the start of each period.

Top module: `skew_clock_gen`

## Requirements
- R1: The range select picks the period N: LOW gives 44, MID gives 26 and HIGH gives 16 time-unit clock cycles. `period_start_o` pulses every N cycles.
- R2: With code MM, a pair is high for N/2 cycles and then low for N/2 cycles. It rises in the same cycle that `period_start_o` is high.
- R3: On pairs 1 and 2, code index i = 3·F1 + F0 (L=0, M=1, H=2) gives a skew of k = i−4 time units. The output is the MM waveform delayed by k cycles, taken modulo N, so a negative k leads.
- R4: On pairs 3 and 4, indices 1 to 7 give a skew of k = 2·(i−4), applied the same way.
- R5: Code LL on pairs 3 and 4 gives half rate. The output toggles at each period start and is therefore high for one whole period and low for the next.
- R6: Code HH on pair 3 gives quarter rate, high for two periods and low for two.
- R7: Code HH on pair 4 gives the MM waveform inverted.
- R8: Each select is 2 bits wide: 00 is LOW, 01 is MID, 10 is HIGH, and 11 is treated as MID. Pair p (0-based) uses `fsel_i[4p+3:4p+2]` as F1 and `fsel_i[4p+1:4p]` as F0. It drives `clk_o[2p]` and `clk_o[2p+1]` with the same value.
- R9: The range and the pair selects are sampled only in the cycle that the counter wraps, and once after reset. A change in the middle of a period has no effect before the next period start.
- R10: `period_start_o` is high for exactly one cycle per period, including the first period after reset.
- R11: When the test select is not 00, every output follows `ref_i` two cycles later, with skew ignored. HH on pair 4 inverts the reference. LL and HH on pair 3, and LL on pair 4, divide by counting rising edges of the reference. In this mode the selects act live.
- R12: While `rst_ni` is low, and in the first cycle after its release, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Time-unit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| range_sel_i | input | 2 | Three-level period range select |
| fsel_i | input | 16 | Two three-level function selects per pair |
| test_i | input | 2 | Three-level bypass select |
| ref_i | input | 1 | Reference level used in bypass |
| clk_o | output | 8 | Registered clock outputs, two per pair |
| period_start_o | output | 1 | One-cycle strobe at each period start |

## Verification
Two events can land in the same cycle: the counter wrap, which captures the configuration and steps the dividers, and a change on the selects or the range. The bench watches the strobe and drives new selects exactly on the last cycle of a period, so they are captured at that wrap. It also drives changes a few cycles inside a period, where they must wait for the next wrap. Each case is judged against a cycle model in the bench, which captures at the wrap and otherwise holds the old configuration. A second coincidence is a reference rising edge in the cycle the bypass is entered or left.

// File: rtl/skew_pkg.sv
package skew_pkg;

  localparam int NUM_PAIRS = 4;

  localparam int KIND_FINE = 0;
  localparam int KIND_DIV4 = 1;
  localparam int KIND_INV  = 2;

  typedef enum logic [1:0] {
    FN_SKEW = 2'd0,
    FN_DIV2 = 2'd1,
    FN_DIV4 = 2'd2,
    FN_INV  = 2'd3
  } pair_fn_e;

  typedef struct packed {
    pair_fn_e    fn;
    logic [3:0]  skew;  // two's complement time units
  } pair_cfg_t;

  // 11 folds onto MID
  function automatic logic [1:0] tern_lvl(input logic [1:0] v);
    case (v)
      2'b00:   tern_lvl = 2'd0;
      2'b10:   tern_lvl = 2'd2;
      default: tern_lvl = 2'd1;
    endcase
  endfunction

  function automatic pair_cfg_t decode_sel(input logic [3:0] code, input int kind);
    pair_cfg_t r;
    int idx;
    idx    = 3 * int'(tern_lvl(code[3:2])) + int'(tern_lvl(code[1:0]));
    r.fn   = FN_SKEW;
    r.skew = 4'(idx - 4);
    if (kind != KIND_FINE) begin
      if (idx == 0) begin
        r.fn   = FN_DIV2;
        r.skew = 4'd0;
      end else if (idx == 8) begin
        r.fn   = (kind == KIND_DIV4) ? FN_DIV4 : FN_INV;
        r.skew = 4'd0;
      end else begin
        r.skew = 4'(2 * (idx - 4));
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/skew_phase_counter.sv
module skew_phase_counter
  import skew_pkg::*;
#(
  parameter int N_LOW  = 44,
  parameter int N_MID  = 26,
  parameter int N_HIGH = 16,
  parameter int CNT_W  = $clog2(N_LOW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       range_sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] n_o,
  output logic             init_o,
  output logic             load_o,
  output logic             wrap_o,
  output logic             period_start_o
);

  logic [CNT_W-1:0] cnt_q, n_q, n_sel;
  logic             init_q, ps_q, wrap, load;

  always_comb begin
    case (tern_lvl(range_sel_i))
      2'd0:    n_sel = CNT_W'(N_LOW);
      2'd2:    n_sel = CNT_W'(N_HIGH);
      default: n_sel = CNT_W'(N_MID);
    endcase
  end

  assign wrap = !init_q && (cnt_q == n_q - 1'b1);
  assign load = init_q || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      n_q    <= CNT_W'(N_LOW);
      init_q <= 1'b1;
      ps_q   <= 1'b0;
    end else begin
      ps_q   <= !init_q && (cnt_q == '0);
      init_q <= 1'b0;
      if (load) begin
        cnt_q <= '0;
        n_q   <= n_sel;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o          = cnt_q;
  assign n_o            = n_q;
  assign init_o         = init_q;
  assign load_o         = load;
  assign wrap_o         = wrap;
  assign period_start_o = ps_q;

  // R1
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < n_q);
  // R9
  n_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(n_q));
  // R10
  strobe_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_q |-> (cnt_q == CNT_W'(1)));
  // R1
  wrap_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (cnt_q == '0));

endmodule

// File: rtl/skew_ref_sync.sv
module skew_ref_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic lvl_o,
  output logic rise_o
);

  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= ref_i;
      s2_q <= s1_q;
    end
  end

  assign lvl_o  = s2_q;
  // edge seen one stage early so divided outputs align with plain ones
  assign rise_o = s1_q && !s2_q;

  // R11
  rise_then_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> lvl_o);

endmodule

// File: rtl/skew_pair_out.sv
module skew_pair_out
  import skew_pkg::*;
#(
  parameter int KIND  = KIND_FINE,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic             init_i,
  input  logic             load_i,
  input  logic             wrap_i,
  input  logic             bypass_i,
  input  logic             ref_lvl_i,
  input  logic             ref_rise_i,
  input  logic [3:0]       code_i,
  output logic             out_o
);

  localparam int DW = CNT_W + 2;

  logic [3:0]           code_q;
  logic [1:0]           div_q;
  logic                 out_q, evt, skew_lvl, base, nxt;
  pair_cfg_t            cfg;
  logic signed [DW-1:0] sk_ext, diff, ph, n_s, half_s;

  assign cfg = bypass_i ? decode_sel(code_i, KIND) : decode_sel(code_q, KIND);
  assign evt = bypass_i ? ref_rise_i : wrap_i;

  always_comb begin
    sk_ext = {{(DW-4){cfg.skew[3]}}, cfg.skew};
    n_s    = {2'b00, n_i};
    half_s = {3'b000, n_i[CNT_W-1:1]};
    diff   = {2'b00, cnt_i} - sk_ext;
    if (diff[DW-1])        ph = diff + n_s;
    else if (diff >= n_s)  ph = diff - n_s;
    else                   ph = diff;
    skew_lvl = ph < half_s;
    base     = bypass_i ? ref_lvl_i : skew_lvl;
    case (cfg.fn)
      FN_DIV2: nxt = div_q[0];
      FN_DIV4: nxt = div_q[1];
      FN_INV:  nxt = !base;
      default: nxt = base;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= 4'b0101;
      div_q  <= '0;
      out_q  <= 1'b0;
    end else begin
      if (load_i) code_q <= code_i;
      if (evt)    div_q  <= div_q + 1'b1;
      out_q <= init_i ? 1'b0 : nxt;
    end
  end

  assign out_o = out_q;

  // R9
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(code_q));
  // R5
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt |=> $stable(div_q));
  // R12
  init_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !out_q);

endmodule

// File: rtl/skew_clock_gen.sv
module skew_clock_gen
  import skew_pkg::*;
#(
  parameter int N_LOW  = 44,
  parameter int N_MID  = 26,
  parameter int N_HIGH = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             range_sel_i,
  input  logic [4*NUM_PAIRS-1:0] fsel_i,
  input  logic [1:0]             test_i,
  input  logic                   ref_i,
  output logic [2*NUM_PAIRS-1:0] clk_o,
  output logic                   period_start_o
);

  localparam int CNT_W = $clog2(N_LOW);

  logic [CNT_W-1:0] cnt, n;
  logic             init, load, wrap, ref_lvl, ref_rise, bypass;

  assign bypass = (test_i != 2'b00);

  skew_phase_counter #(
    .N_LOW (N_LOW),
    .N_MID (N_MID),
    .N_HIGH(N_HIGH),
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .range_sel_i   (range_sel_i),
    .cnt_o         (cnt),
    .n_o           (n),
    .init_o        (init),
    .load_o        (load),
    .wrap_o        (wrap),
    .period_start_o(period_start_o)
  );

  skew_ref_sync u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ref_i (ref_i),
    .lvl_o (ref_lvl),
    .rise_o(ref_rise)
  );

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    localparam int KIND = (g < 2) ? KIND_FINE : ((g == 2) ? KIND_DIV4 : KIND_INV);
    logic out;

    skew_pair_out #(
      .KIND (KIND),
      .CNT_W(CNT_W)
    ) u_pair (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_i     (cnt),
      .n_i       (n),
      .init_i    (init),
      .load_i    (load),
      .wrap_i    (wrap),
      .bypass_i  (bypass),
      .ref_lvl_i (ref_lvl),
      .ref_rise_i(ref_rise),
      .code_i    (fsel_i[4*g +: 4]),
      .out_o     (out)
    );

    assign clk_o[2*g]   = out;
    assign clk_o[2*g+1] = out;
  end

endmodule

// File: tb/skew_clock_gen_test.sv
module skew_clock_gen_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rng = 2'b01;
  logic [15:0] fsel = 16'h5555;
  logic [1:0]  test = 2'b00;
  logic        ref_r = 1'b0;
  logic [7:0]  clk_o;
  logic        ps_o;

  int    vectors = 0;
  int    fails = 0;
  string cur = "R12";
  int    cur_n = 26;

  always #(CLK_PERIOD/2) clk = ~clk;

  skew_clock_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .range_sel_i(rng), .fsel_i(fsel),
    .test_i(test), .ref_i(ref_r), .clk_o(clk_o), .period_start_o(ps_o)
  );

  // behavioural reference model
  int         m_cnt, m_n, m_div[4];
  bit         m_init, m_s1, m_s2;
  logic [3:0] m_code[4];
  logic [7:0] e_clk;
  logic       e_ps;

  function automatic int tern(logic [1:0] v);
    return (v == 2'b00) ? 0 : ((v == 2'b10) ? 2 : 1);
  endfunction

  function automatic int rng_n(logic [1:0] v);
    case (tern(v))
      0: return 44;
      2: return 16;
      default: return 26;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_n = 44; m_init = 1; m_s1 = 0; m_s2 = 0;
      for (int p = 0; p < 4; p++) begin m_code[p] = 4'b0101; m_div[p] = 0; end
      e_clk = '0; e_ps = 0;
    end else begin
      bit byp, evt, wr;
      byp = (test != 2'b00);
      for (int p = 0; p < 4; p++) begin
        logic [3:0] c;
        int idx, sk, mode, ph;
        bit lvl, o;
        c = byp ? fsel[4*p +: 4] : m_code[p];
        idx = 3 * tern(c[3:2]) + tern(c[1:0]);
        sk = 0; mode = 0;
        if (p < 2) sk = idx - 4;
        else if (idx == 0) mode = 1;
        else if (idx == 8) mode = (p == 2) ? 2 : 3;
        else sk = 2 * (idx - 4);
        if (byp) lvl = m_s2;
        else begin
          ph = (((m_cnt - sk) % m_n) + m_n) % m_n;
          lvl = (ph < m_n / 2);
        end
        case (mode)
          1: o = m_div[p][0];
          2: o = m_div[p][1];
          3: o = !lvl;
          default: o = lvl;
        endcase
        if (m_init) o = 0;
        e_clk[2*p] = o; e_clk[2*p+1] = o;
      end
      e_ps = !m_init && (m_cnt == 0);
      evt = byp ? (m_s1 && !m_s2) : (!m_init && m_cnt == m_n - 1);
      if (evt) for (int p = 0; p < 4; p++) m_div[p] = (m_div[p] + 1) % 4;
      wr = m_init || (m_cnt == m_n - 1);
      m_s2 = m_s1; m_s1 = ref_r;
      if (wr) begin
        m_cnt = 0; m_n = rng_n(rng); m_init = 0;
        for (int p = 0; p < 4; p++) m_code[p] = fsel[4*p +: 4];
      end else m_cnt++;
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (clk_o !== e_clk || ps_o !== e_ps) begin
      fails++;
      $display("FAIL %s: clk_o=%h ps=%b expected clk_o=%h ps=%b", cur, clk_o, ps_o, e_clk, e_ps);
    end
  end

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic measure(int exp, string tag);
    int c;
    c = 0;
    @(negedge clk); while (!ps_o) @(negedge clk);
    do begin @(negedge clk); c++; end while (!ps_o && c < 100);
    vectors++;
    if (c != exp) begin
      fails++;
      $display("FAIL %s: period=%0d expected %0d", tag, c, exp);
    end
  endtask

  // drive new selects on the last cycle of a period
  task automatic at_wrap(logic [15:0] f);
    @(negedge clk); while (!ps_o) @(negedge clk);
    step(cur_n - 2);
    fsel = f;
  endtask

  task automatic ref_run(int n);
    for (int i = 0; i < n; i++) begin
      ref_r = ~ref_r;
      step(2 + (i * 7) % 8);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    step(150000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    // R12: reset state
    step(4);
    vectors++;
    if (clk_o !== 8'h00 || ps_o !== 1'b0) begin
      fails++;
      $display("FAIL R12: clk_o=%h ps=%b expected 00/0", clk_o, ps_o);
    end
    rst_n = 1'b1;
    cur = "R2 R10"; step(120);
    measure(26, "R1");
    cur = "R3 R4";
    fsel = {4'b1001, 4'b0001, 4'b1010, 4'b0000};
    step(100);
    cur = "R5 R7 R1";
    rng = 2'b10; cur_n = 16;
    fsel = {4'b1010, 4'b0000, 4'b0110, 4'b0100};
    step(100);
    measure(16, "R1");
    cur = "R6 R8";
    rng = 2'b11; cur_n = 26;
    fsel = {4'b1101, 4'b1010, 4'b0111, 4'b1000};
    step(250);
    measure(26, "R8");
    cur = "R9";
    rng = 2'b00; step(60); cur_n = 44;
    for (int i = 0; i < 6; i++) begin
      fsel = fsel ^ (16'h1248 << (i % 3));
      step(7 + i);
    end
    at_wrap({4'b0001, 4'b1001, 4'b0000, 4'b1010});
    step(3);
    at_wrap({4'b0000, 4'b1010, 4'b1001, 4'b0001});
    step(1);
    fsel = {4'b1010, 4'b0000, 4'b0101, 4'b0101};
    step(200);
    measure(44, "R9");
    cur = "R11";
    test = 2'b01; ref_run(30);
    fsel = {4'b0000, 4'b1010, 4'b0001, 4'b1010};
    test = 2'b10; ref_r = 1'b1; ref_run(30);
    fsel = {4'b1010, 4'b0000, 4'b1001, 4'b0100};
    test = 2'b11; ref_run(30);
    cur = "R2";
    test = 2'b00; step(150);
    finish_up();
  end

endmodule